// File: doc/BRIEF.md
# Step Event Spacing Enforcer

The block takes single-step angle events, each an up or a down strobe, from a flash angle converter. That converter's position code moves through 64 levels per input signal cycle. The block forwards the steps to a quadrature back end. It guarantees that two forwarded steps are never closer together than a programmable number of clock cycles.

An event that respects the spacing leaves through the output register on the next clock edge, with no extra wait. An event that comes too early is not lost. It is counted in a signed backlog and released once the gap has run out, one step per gap.

The block does not sample on a free-running clock. Outputs appear only when a step is pending. Opposite steps that are still waiting cancel each other. The spacing seen at the final quadrature outputs is this gap multiplied by the downstream divider (1, 2, 4, 8 or 16). That scaling is applied outside this block.

The step strobes form a push-only stream. There is no ready signal and no back-pressure. Each strobe is accepted in the cycle it is high. The only loss is past the backlog limit, and that loss is reported.

Top module: `step_spacer`

## Requirements
- R1: After reset, `fwd_up_o`, `fwd_dn_o` and `overflow_o` are 0, the backlog is empty, and the gap timer counts as expired, so the first step is forwarded at once.
- R2: A step that arrives with an empty backlog and an expired gap appears on the matching output one clock after the cycle its strobe is high, for exactly one cycle.
- R3: With `gap_i` greater than 1, two consecutive output pulses (up or down) are at least `gap_i` cycles apart.
- R4: Steps that arrive while the gap is running are held and released one per gap, in order of direction sign. No step is dropped while the backlog magnitude is below 15.
- R5: A `gap_i` of 0 or 1 disables spacing: a step in every cycle is forwarded in every cycle.
- R6: Pending steps of opposite direction cancel. An up and a down strobe in the same cycle have no net effect on the outputs.
- R7: The backlog saturates at +15 and -15. A further step in the saturated direction is dropped, and `overflow_o` goes to 1 and stays 1 until reset.
- R8: `fwd_up_o` and `fwd_dn_o` are never 1 in the same cycle.
- R9: When no step is pending and none arrives, both outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_up_i | input | 1 | One upward step event in this cycle |
| step_dn_i | input | 1 | One downward step event in this cycle |
| gap_i | input | 12 | Minimum spacing in clock cycles between forwarded steps; 0 or 1 disables spacing |
| fwd_up_o | output | 1 | Registered forwarded upward step |
| fwd_dn_o | output | 1 | Registered forwarded downward step |
| overflow_o | output | 1 | Sticky flag: a step was dropped because the backlog was full |

## Verification
A corrupted backlog shows up at the ports as output pulses that are missing, extra or in the wrong direction. The bench counts these pulses, so the error is seen no later than one gap after the fault.

A timer that reloads or expires wrongly changes the distance between pulses. This shows on the first held step, one cycle after that step's release decision.

An error in the saturation logic shows as a wrong number of steps released after a long burst, or as a wrong `overflow_o` value. Both are compared against a behavioural model on every clock.

// File: rtl/spacer_pkg.sv
package spacer_pkg;
  // Direction of a forwarded step decided in one cycle
  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DN   = 2'b10
  } step_dir_e;

  function automatic step_dir_e pick_dir(input logic up, input logic dn);
    if (up && !dn) return STEP_UP;
    if (dn && !up) return STEP_DN;
    return STEP_NONE;
  endfunction
endpackage

// File: rtl/spacer_gap_timer.sv
module spacer_gap_timer #(
  parameter int GAP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             ready_o
);
  localparam logic [GAP_W-1:0] CNT_MAX = {GAP_W{1'b1}};
  localparam logic [GAP_W-1:0] CNT_ONE = GAP_W'(1);

  logic [GAP_W-1:0] since_q;

  // Cycles since the last release decision; saturates, starts expired
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q <= CNT_MAX;
    end else if (fire_i) begin
      since_q <= CNT_ONE;
    end else if (since_q != CNT_MAX) begin
      since_q <= since_q + CNT_ONE;
    end
  end

  assign ready_o = (gap_i <= CNT_ONE) || (since_q >= gap_i);

  // R3: right after a release the gap must be running again
  assert_gap_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && gap_i > CNT_ONE) |=> (!ready_o || gap_i <= CNT_ONE));
endmodule

// File: rtl/spacer_backlog.sv
module spacer_backlog #(
  parameter int BACKLOG_MAX = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_i,
  input  logic dn_i,
  input  logic ready_i,
  output logic emit_up_o,
  output logic emit_dn_o,
  output logic signed [$clog2(BACKLOG_MAX+1):0] level_o,
  output logic overflow_o
);
  localparam int BL_W = $clog2(BACKLOG_MAX+1) + 1;
  localparam int CW   = BL_W + 1;
  localparam logic signed [CW-1:0] LIM_P = CW'(BACKLOG_MAX);
  localparam logic signed [CW-1:0] LIM_N = -CW'(BACKLOG_MAX);
  localparam logic signed [CW-1:0] ONE_C = CW'(1);

  logic signed [BL_W-1:0] level_q;
  logic signed [CW-1:0]   step_c, sum_c, left_c, clip_c;
  logic                   ovf_q, clip_hit;

  always_comb begin
    unique case ({up_i, dn_i})
      2'b10:   step_c = ONE_C;
      2'b01:   step_c = -ONE_C;
      default: step_c = '0;
    endcase
    sum_c     = {level_q[BL_W-1], level_q} + step_c;
    emit_up_o = ready_i && (sum_c > 0);
    emit_dn_o = ready_i && sum_c[CW-1];
    if (emit_up_o)      left_c = sum_c - ONE_C;
    else if (emit_dn_o) left_c = sum_c + ONE_C;
    else                left_c = sum_c;
    clip_hit = 1'b0;
    clip_c   = left_c;
    if (left_c > LIM_P) begin
      clip_c   = LIM_P;
      clip_hit = 1'b1;
    end else if (left_c < LIM_N) begin
      clip_c   = LIM_N;
      clip_hit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      level_q <= clip_c[BL_W-1:0];
      ovf_q   <= ovf_q || clip_hit;
    end
  end

  assign level_o    = level_q;
  assign overflow_o = ovf_q;

  // R7: the drop flag never clears on its own
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  // R4: a held up-step below the limit is added to the backlog
  assert_no_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_i && up_i && !dn_i && (level_q >= 0) && (level_q < BL_W'(BACKLOG_MAX)))
    |=> level_q == $past(level_q) + BL_W'(1));
endmodule

// File: rtl/step_spacer.sv
module step_spacer
  import spacer_pkg::*;
#(
  parameter int GAP_W       = 12,
  parameter int BACKLOG_MAX = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up_i,
  input  logic             step_dn_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             fwd_up_o,
  output logic             fwd_dn_o,
  output logic             overflow_o
);
  localparam int BL_W = $clog2(BACKLOG_MAX+1) + 1;

  logic                   ready, emit_up, emit_dn;
  logic signed [BL_W-1:0] level;
  step_dir_e              dir_q;

  spacer_gap_timer #(.GAP_W(GAP_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (emit_up || emit_dn),
    .gap_i   (gap_i),
    .ready_o (ready)
  );

  spacer_backlog #(.BACKLOG_MAX(BACKLOG_MAX)) u_backlog (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_i       (step_up_i),
    .dn_i       (step_dn_i),
    .ready_i    (ready),
    .emit_up_o  (emit_up),
    .emit_dn_o  (emit_dn),
    .level_o    (level),
    .overflow_o (overflow_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) dir_q <= STEP_NONE;
    else        dir_q <= pick_dir(emit_up, emit_dn);
  end

  assign fwd_up_o = (dir_q == STEP_UP);
  assign fwd_dn_o = (dir_q == STEP_DN);

  // Checker state: spacing between output pulses
  logic [GAP_W-1:0] chk_since_q, chk_gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_since_q <= {GAP_W{1'b1}};
      chk_gap_q   <= '0;
    end else begin
      chk_gap_q <= gap_i;
      if (fwd_up_o || fwd_dn_o)           chk_since_q <= GAP_W'(1);
      else if (chk_since_q != {GAP_W{1'b1}}) chk_since_q <= chk_since_q + GAP_W'(1);
    end
  end

  assert_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((fwd_up_o || fwd_dn_o) && chk_gap_q > GAP_W'(1)) |-> chk_since_q >= chk_gap_q);
  assert_zero_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && level == 0 && step_up_i && !step_dn_i) |=> fwd_up_o);
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_up_o && fwd_dn_o));
endmodule

// File: tb/test_step_spacer.sv
module test_step_spacer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_in = 1'b0, dn_in = 1'b0;
  logic [11:0] gap = 12'd0;
  logic up_o, dn_o, ovf_o;

  always #10 clk = ~clk;

  step_spacer i_step_spacer (
    .clk(clk), .rst_n(rst_n), .step_up_i(up_in), .step_dn_i(dn_in),
    .gap_i(gap), .fwd_up_o(up_o), .fwd_dn_o(dn_o), .overflow_o(ovf_o)
  );

  int n_chk = 0, n_bad = 0;
  int m_bl, m_since, cyc, last_pulse, ups_seen, dns_seen;
  bit m_ovf, e_up, e_dn;
  string tag = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    m_bl = 0; m_since = 4095; m_ovf = 0; e_up = 0; e_dn = 0;
    last_pulse = -100000; ups_seen = 0; dns_seen = 0;
  endtask

  task automatic model_step(input bit u, input bit d);
    int c;
    bit rdy;
    rdy = (gap <= 1) || (m_since >= int'(gap));
    c = m_bl + int'(u) - int'(d);
    e_up = rdy && c > 0;
    e_dn = rdy && c < 0;
    if (e_up) c--;
    if (e_dn) c++;
    if (c > 15)  begin c = 15;  m_ovf = 1; end
    if (c < -15) begin c = -15; m_ovf = 1; end
    m_bl = c;
    m_since = (e_up || e_dn) ? 1 : ((m_since < 4095) ? m_since + 1 : 4095);
  endtask

  task automatic step(input bit u, input bit d);
    up_in = u; dn_in = d;
    model_step(u, d);
    @(negedge clk);
    cyc++;
    chk(up_o == e_up, tag, up_o, e_up);
    chk(dn_o == e_dn, tag, dn_o, e_dn);
    chk(ovf_o == m_ovf, {tag, " R7 flag"}, ovf_o, m_ovf);
    chk(!(up_o && dn_o), "R8", int'(up_o && dn_o), 0);
    if (up_o || dn_o) begin
      if (gap > 1) chk(cyc - last_pulse >= int'(gap), "R3", cyc - last_pulse, int'(gap));
      last_pulse = cyc;
    end
    if (up_o) ups_seen++;
    if (dn_o) dns_seen++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  task automatic do_reset();
    rst_n = 0; up_in = 0; dn_in = 0;
    repeat (3) @(negedge clk);
    model_reset();
    tag = "R1";
    chk(up_o == 0 && dn_o == 0, "R1", int'(up_o | dn_o), 0);
    chk(ovf_o == 0, "R1", ovf_o, 0);
    rst_n = 1;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    report();
  end

  initial begin
    cyc = 0;
    model_reset();
    do_reset();
    // R1/R2: first step after reset forwarded on the next cycle
    gap = 12'd5; tag = "R2";
    step(1, 0);
    chk(up_o == 1, "R2", up_o, 1);
    step(0, 0);
    chk(up_o == 0, "R2", up_o, 0);
    idle(6);
    // R4: burst held and released one per gap
    tag = "R4"; ups_seen = 0;
    for (int i = 0; i < 4; i++) step(1, 0);
    idle(25);
    chk(ups_seen == 4, "R4", ups_seen, 4);
    // R9: nothing pending, nothing comes out
    tag = "R9"; ups_seen = 0; dns_seen = 0;
    idle(20);
    chk(ups_seen + dns_seen == 0, "R9", ups_seen + dns_seen, 0);
    // R5: gap 0 and 1 pass a step every cycle
    for (int g = 0; g < 2; g++) begin
      gap = 12'(g); tag = "R5"; dns_seen = 0;
      for (int i = 0; i < 6; i++) step(0, 1);
      step(0, 0);
      chk(dns_seen == 6, "R5", dns_seen, 6);
    end
    // R6: opposite steps cancel in the backlog and in the same cycle
    gap = 12'd10; idle(12); tag = "R6"; ups_seen = 0; dns_seen = 0;
    step(1, 0); step(1, 0); step(0, 1);
    idle(30);
    chk(ups_seen == 1 && dns_seen == 0, "R6", ups_seen * 10 + dns_seen, 10);
    step(1, 1);
    idle(3);
    chk(ups_seen == 1 && dns_seen == 0, "R6", ups_seen * 10 + dns_seen, 10);
    // R3: downward burst with a long gap
    gap = 12'd7; tag = "R3"; dns_seen = 0;
    for (int i = 0; i < 3; i++) step(0, 1);
    idle(20);
    chk(dns_seen == 3, "R3", dns_seen, 3);
    // R7: saturation drops excess, flag sticks
    gap = 12'd100; idle(100); tag = "R7"; ups_seen = 0;
    for (int i = 0; i < 21; i++) step(1, 0);
    chk(ovf_o == 1, "R7", ovf_o, 1);
    idle(1600);
    chk(ups_seen == 16, "R7", ups_seen, 16);
    chk(ovf_o == 1, "R7", ovf_o, 1);
    // R1: reset clears the flag and timer is expired again
    do_reset();
    tag = "R1";
    step(0, 1);
    chk(dn_o == 1, "R1", dn_o, 1);
    idle(5);
    report();
  end
endmodule